// File: doc/BRIEF.md
# Low-Power Mode Register Controller

This block is the device-side control logic that governs the sleep behaviour of a 1M x 16 pseudo-static RAM. It samples the asynchronous chip select, write enable, byte enables, the active-low sleep pin and the five lowest address bits on a system clock. While the sleep pin is low, an ordinary write cycle does not touch the array. Instead, the low address bits are latched as a pending configuration word, and that word takes effect when the sleep pin rises.

When the sleep pin stays low for 1 us with no new write cycle starting, the block enters the configured sleep state. That state is either a partial self-refresh of a selected window or a one-shot deep power down. Deep power down invalidates the array and restores every configuration field to its default on exit. A reduced-memory-size setting narrows the refresh window even while the part is awake. All waits are counted in clock cycles derived from the `CLK_HZ` parameter: the power-up wait, the 1 us window, the 10 us minimum sleep time and the deep power down recovery.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, mode is 0 (power-up wait), with ready and data_valid low. The block moves to standby (mode 1) only after 200 us worth of cycles.
- R2: Every pin passes through a two-flop synchroniser. A pin change made between clock edges reaches mode on the third rising edge after it.
- R3: The pending word is captured only when all of the following hold: chip select low, write enable low, at least one byte enable low, and the sleep pin low. The word is committed on the sleep pin's rising edge. A write cycle with the sleep pin high leaves the configuration unchanged.
- R4: The configuration word fields are: addr_lo[4] = 0 arms deep power down (1 = off, default); addr_lo[3] = 1 selects reduced memory size (0 = partial refresh, default); addr_lo[2] = 1 selects the top part (0 = bottom, default); addr_lo[1:0] is the area code (00 full, default; 01 reserved, treated as full; 10 half; 11 quarter).
- R5: With the sleep pin low, the block waits in mode 3 (armed) and enters sleep after 1 us of cycles. The start of a write cycle during that wait restarts the 1 us count.
- R6: The reported window is one of: bottom quarter 00000h-3FFFFh, bottom half 00000h-7FFFFh, top quarter C0000h-FFFFFh, top half 80000h-FFFFFh, or full 00000h-FFFFFh.
- R7: In partial refresh mode the window is full while awake and narrowed only in mode 4 (partial refresh).
- R8: In reduced memory size mode the window is narrowed while awake too, and stays so across sleep periods until the configuration is rewritten.
- R9: If deep power down is armed, sleep entry goes to mode 5 and drops data_valid. On exit all fields return to default, so the next sleep goes to partial refresh.
- R10: Modes 4 and 5 last at least 10 us of cycles, even if the sleep pin rises earlier.
- R11: Deep power down exits to mode 6 (recovery) for 200 us of cycles, then returns to standby.
- R12: ready is high only in standby (1) and active (2). Active is entered when chip select is low with a byte enable low, and left when the part is deselected.
- R13: data_valid goes high on a write cycle in active mode and stays low from deep power down entry until such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| lb_n | input | 1 | Lower byte enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| sleep_n | input | 1 | Sleep pin, low requests low power |
| addr_lo | input | 5 | Low address bits carrying the configuration word |
| mode | output | 3 | Current mode code |
| win_lo | output | AW | Lowest address of the refreshed window |
| win_hi | output | AW | Highest address of the refreshed window |
| data_valid | output | 1 | Array contents are trustworthy |
| ready | output | 1 | Part accepts accesses |

## Verification
The bound checker watches, on every cycle, several rules tied to mode and configuration. It checks the minimum residence in both sleep modes, using its own cycle counter. It checks that deep power down leaves only to recovery, that data stays invalid in deep power down, and that defaults hold during recovery. It also checks that the configuration only changes after a sleep-pin rise or a deep power down exit, and that the window is always ordered. Other behaviours only show up in the bench's scenarios: the address decode of each field, the exact 1 us entry delay and its restart by a write, and the persistence of reduced memory size across sleeps. The same goes for the ignored write with the sleep pin high and the 200 us waits.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    M_INIT   = 3'd0,
    M_STBY   = 3'd1,
    M_ACTIVE = 3'd2,
    M_ARM    = 3'd3,
    M_PAR    = 3'd4,
    M_DPD    = 3'd5,
    M_RECOV  = 3'd6
  } lpm_mode_e;

  typedef struct packed {
    logic       dpd_off;
    logic       rms;
    logic       top;
    logic [1:0] area;
  } lpm_cfg_t;

  localparam lpm_cfg_t CFG_DEFAULT = '{dpd_off: 1'b1, rms: 1'b0, top: 1'b0, area: 2'b00};

  // converts microseconds to clock cycles, never less than one
  function automatic int unsigned us_to_cyc(longint unsigned hz, int unsigned us);
    longint unsigned c;
    c = (hz * longint'(us)) / 64'd1000000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  // number of words in the refreshed window
  function automatic longint unsigned win_size(lpm_cfg_t c, logic scoped, int aw);
    if (scoped && c.area == 2'b10) return 64'd1 << (aw - 1);
    if (scoped && c.area == 2'b11) return 64'd1 << (aw - 2);
    return 64'd1 << aw;
  endfunction

  function automatic longint unsigned win_base(lpm_cfg_t c, logic scoped, int aw);
    longint unsigned sz;
    sz = win_size(c, scoped, aw);
    return c.top ? ((64'd1 << aw) - sz) : 64'd0;
  endfunction

  function automatic longint unsigned win_last(lpm_cfg_t c, logic scoped, int aw);
    return win_base(c, scoped, aw) + win_size(c, scoped, aw) - 64'd1;
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= din[i];
        s2 <= s1;
      end
    end
    assign dout[i] = s2;
  end
endmodule

// File: rtl/lpm_cfgreg.sv
module lpm_cfgreg
  import lpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  lpm_cfg_t cap_val,
  input  logic     commit,
  input  logic     drop_pend,
  input  logic     restore,
  output lpm_cfg_t cfg
);
  lpm_cfg_t pend;
  logic     pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= CFG_DEFAULT;
      pend     <= CFG_DEFAULT;
      pend_vld <= 1'b0;
    end else begin
      if (restore) begin
        cfg      <= CFG_DEFAULT;
        pend_vld <= 1'b0;
      end else if (drop_pend) begin
        pend_vld <= 1'b0;
      end else if (capture) begin
        pend     <= cap_val;
        pend_vld <= 1'b1;
      end else if (commit && pend_vld) begin
        cfg      <= pend;
        pend_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned WIN_CYC = 100,
  parameter int unsigned MIN_CYC = 1000,
  parameter int unsigned REC_CYC = 20000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_s,
  input  logic      sel,
  input  logic      wr_act,
  input  logic      wr_start,
  input  logic      dpd_off,
  output lpm_mode_e state,
  output logic      dpd_enter,
  output logic      dpd_exit,
  output logic      data_valid
);
  localparam int unsigned MAXC = (REC_CYC > MIN_CYC) ? REC_CYC : MIN_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] MIN_LAST = CW'(MIN_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  lpm_mode_e      nxt;
  logic [CW-1:0]  cnt, cnt_nxt;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      M_INIT, M_RECOV: begin
        if (cnt == REC_LAST) begin
          nxt     = M_STBY;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      M_STBY, M_ACTIVE: begin
        cnt_nxt = '0;
        if (!sleep_s)  nxt = M_ARM;
        else if (sel)  nxt = M_ACTIVE;
        else           nxt = M_STBY;
      end
      M_ARM: begin
        if (sleep_s) begin
          nxt     = M_STBY;
          cnt_nxt = '0;
        end else if (wr_start) begin
          cnt_nxt = '0;
        end else if (cnt == WIN_LAST) begin
          nxt     = dpd_off ? M_PAR : M_DPD;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      M_PAR, M_DPD: begin
        if (cnt != MIN_LAST) cnt_nxt = cnt + 1'b1;
        if (sleep_s && cnt == MIN_LAST) begin
          nxt     = (state == M_DPD) ? M_RECOV : M_STBY;
          cnt_nxt = '0;
        end
      end
      default: begin
        nxt     = M_INIT;
        cnt_nxt = '0;
      end
    endcase
  end

  assign dpd_enter = (state == M_ARM) && (nxt == M_DPD);
  assign dpd_exit  = (state == M_DPD) && (nxt == M_RECOV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= M_INIT;
      cnt        <= '0;
      data_valid <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
      if (dpd_enter)                             data_valid <= 1'b0;
      else if (state == M_ACTIVE && wr_act && sleep_s) data_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd100000000,
  parameter int              AW     = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic          sleep_n,
  input  logic [4:0]    addr_lo,
  output logic [2:0]    mode,
  output logic [AW-1:0] win_lo,
  output logic [AW-1:0] win_hi,
  output logic          data_valid,
  output logic          ready
);
  localparam int unsigned WIN_CYC = us_to_cyc(CLK_HZ, 1);
  localparam int unsigned MIN_CYC = us_to_cyc(CLK_HZ, 10);
  localparam int unsigned REC_CYC = us_to_cyc(CLK_HZ, 200);
  localparam int          NPIN    = 10;

  logic [NPIN-1:0] pins_s;
  logic            cs_s, we_s, lb_s, ub_s, sleep_s;
  logic [4:0]      addr_s;
  logic            zz_q, wr_q;

  lpm_sync #(.W(NPIN), .RST_VAL({5'b00000, 5'b11111})) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({addr_lo, sleep_n, ub_n, lb_n, we_n, cs_n}),
    .dout(pins_s)
  );
  assign {addr_s, sleep_s, ub_s, lb_s, we_s, cs_s} = pins_s;

  // named events used by the checker
  logic sel_w, wr_act_w, wr_start_w, zz_rise_w, capture_w;
  logic dpd_enter_w, dpd_exit_w, scoped_w;
  lpm_mode_e state_w;
  lpm_cfg_t  cfg_w;

  assign sel_w      = !cs_s && (!lb_s || !ub_s);
  assign wr_act_w   = sel_w && !we_s;
  assign wr_start_w = wr_act_w && !wr_q;
  assign zz_rise_w  = sleep_s && !zz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zz_q <= 1'b1;
      wr_q <= 1'b0;
    end else begin
      zz_q <= sleep_s;
      wr_q <= wr_act_w;
    end
  end

  lpm_fsm #(.WIN_CYC(WIN_CYC), .MIN_CYC(MIN_CYC), .REC_CYC(REC_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sleep_s(sleep_s), .sel(sel_w), .wr_act(wr_act_w), .wr_start(wr_start_w),
    .dpd_off(cfg_w.dpd_off),
    .state(state_w), .dpd_enter(dpd_enter_w), .dpd_exit(dpd_exit_w),
    .data_valid(data_valid)
  );

  assign capture_w = wr_act_w && !sleep_s &&
                     (state_w == M_STBY || state_w == M_ACTIVE || state_w == M_ARM);

  lpm_cfgreg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .capture(capture_w), .cap_val(lpm_cfg_t'(addr_s)),
    .commit(zz_rise_w), .drop_pend(dpd_enter_w), .restore(dpd_exit_w),
    .cfg(cfg_w)
  );

  assign scoped_w = cfg_w.rms || (state_w == M_PAR);
  assign win_lo   = AW'(win_base(cfg_w, scoped_w, AW));
  assign win_hi   = AW'(win_last(cfg_w, scoped_w, AW));
  assign mode     = state_w;
  assign ready    = (state_w == M_STBY) || (state_w == M_ACTIVE);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int          AW      = 20,
  parameter int unsigned MIN_CYC = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic          data_valid,
  input lpm_cfg_t      cfg,
  input logic          zz_rise,
  input logic [AW-1:0] win_lo,
  input logic [AW-1:0] win_hi
);
  logic        in_lp;
  logic [31:0] lp_cnt;
  assign in_lp = (mode == M_PAR) || (mode == M_DPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lp_cnt <= '0;
    else if (in_lp) lp_cnt <= lp_cnt + 1;
    else            lp_cnt <= '0;
  end

  a_r10_min_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lp && lp_cnt < MIN_CYC - 1) |=> (mode == $past(mode)));

  a_r9_dpd_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DPD) |-> !data_valid);

  a_r11_dpd_to_recov: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DPD) |=> (mode == M_DPD || mode == M_RECOV));

  a_r9_defaults_in_recov: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RECOV) |-> (cfg == CFG_DEFAULT));

  a_r3_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> ($past(zz_rise) || $past(mode) == M_DPD));

  a_r1_init_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_INIT) |=> (mode == M_INIT || mode == M_STBY));

  a_r6_window_order: assert property (@(posedge clk) disable iff (!rst_n)
    win_lo <= win_hi);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.AW(AW), .MIN_CYC(MIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .data_valid(data_valid),
  .cfg(cfg_w), .zz_rise(zz_rise_w), .win_lo(win_lo), .win_hi(win_hi)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam longint unsigned HZ = 64'd20000000;
  localparam int WIN = 20, MIN = 200, REC = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1, we_n = 1, lb_n = 1, ub_n = 1, sleep_n = 1;
  logic [4:0] addr_lo = '0;
  logic [2:0] mode;
  logic [19:0] win_lo, win_hi;
  logic data_valid, ready;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lpm_ctrl #(.CLK_HZ(HZ), .AW(20)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n),
    .sleep_n(sleep_n), .addr_lo(addr_lo), .mode(mode), .win_lo(win_lo),
    .win_hi(win_hi), .data_valid(data_valid), .ready(ready)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // expected window {lo,hi} from the configuration word
  function automatic logic [39:0] ew(logic [4:0] a, logic lp);
    logic sc;
    sc = a[3] | lp;
    if (!sc || a[1:0] == 2'b00 || a[1:0] == 2'b01) return {20'h00000, 20'hFFFFF};
    if (a[1:0] == 2'b10) return a[2] ? {20'h80000, 20'hFFFFF} : {20'h00000, 20'h7FFFF};
    return a[2] ? {20'hC0000, 20'hFFFFF} : {20'h00000, 20'h3FFFF};
  endfunction

  task automatic chk_win(string tag, logic [39:0] e);
    chk(tag, {12'h0, win_lo}, {12'h0, e[39:20]});
    chk(tag, {12'h0, win_hi}, {12'h0, e[19:0]});
  endtask

  task automatic pulse_write(logic [4:0] a);
    addr_lo = a; cs_n = 0; we_n = 0; lb_n = 0;
    cyc(2);
    cs_n = 1; we_n = 1; lb_n = 1;
    cyc(2);
  endtask

  task automatic set_cfg(logic [4:0] a);
    sleep_n = 0; cyc(4);
    pulse_write(a);
    sleep_n = 1; cyc(5);
  endtask

  task automatic sleep_par(string tag, logic [4:0] a);
    sleep_n = 0; cyc(3 + WIN + 3);
    chk(tag, mode, 4);
    chk_win(tag, ew(a, 1'b1));
    sleep_n = 1; cyc(MIN + 5);
    chk(tag, mode, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [4:0] a;
    void'($urandom(32'd4711));
    cyc(3);
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 ready", ready, 0); chk("R1 dv", data_valid, 0);
    rst_n = 1;
    cyc(REC - 10);
    chk("R1 still waiting", mode, 0);
    cyc(20);
    chk("R1 standby", mode, 1); chk("R12 ready stby", ready, 1);

    // R2 latency and R12 active
    cs_n = 0; lb_n = 0; addr_lo = 5'b00011;
    cyc(2);
    chk("R2 not yet", mode, 1);
    cyc(1);
    chk("R2 third edge", mode, 2); chk("R12 ready active", ready, 1);
    // R13 write in active; R3 ignored config write with sleep high
    we_n = 0; cyc(4);
    chk("R13 dv set", data_valid, 1);
    we_n = 1; cs_n = 1; lb_n = 1; cyc(4);
    chk("R12 back to stby", mode, 1);
    chk_win("R7 awake full", ew(5'b10000, 1'b0));

    // R5 exact entry delay, R3 no change from ignored write
    sleep_n = 0; cyc(4);
    chk("R5 armed", mode, 3); chk("R12 not ready armed", ready, 0);
    cyc(WIN - 2);
    chk("R5 still armed", mode, 3);
    cyc(1);
    chk("R5 partial", mode, 4);
    chk_win("R3 ignored write", ew(5'b10000, 1'b1));
    sleep_n = 1; cyc(MIN - 3);
    chk("R10 held", mode, 4);
    cyc(5);
    chk("R10 released", mode, 1);

    // R5 restart by write, R4 decode of top quarter
    sleep_n = 0; cyc(10);
    pulse_write(5'b10111);
    cyc(12);
    chk("R5 restarted", mode, 3);
    sleep_n = 1; cyc(5);
    chk("R3 commit stby", mode, 1);
    chk_win("R7 awake still full", ew(5'b10111, 1'b0));
    sleep_par("R4 R6 top quarter", 5'b10111);
    chk_win("R7 full after wake", ew(5'b10111, 1'b0));

    // R8 reduced memory size persists
    set_cfg(5'b11010);
    chk_win("R8 awake narrowed", ew(5'b11010, 1'b0));
    sleep_par("R8 sleep", 5'b11010);
    chk_win("R8 persists", ew(5'b11010, 1'b0));

    // random configurations, deep power down disabled
    for (int i = 0; i < 10; i++) begin
      a = {1'b1, 4'($urandom)};
      set_cfg(a);
      chk_win("R6 R8 awake random", ew(a, 1'b0));
      sleep_par("R6 R7 random", a);
    end

    // R9 deep power down with reduced size, top quarter
    cs_n = 0; lb_n = 0; we_n = 0; cyc(4); we_n = 1; cs_n = 1; lb_n = 1; cyc(4);
    chk("R13 dv before dpd", data_valid, 1);
    set_cfg(5'b01111);
    chk_win("R8 before dpd", ew(5'b01111, 1'b0));
    sleep_n = 0; cyc(3 + WIN + 3);
    chk("R9 dpd", mode, 5); chk("R9 dv low", data_valid, 0);
    sleep_n = 1; cyc(MIN + 5);
    chk("R11 recov", mode, 6); chk("R11 not ready", ready, 0);
    chk_win("R9 defaults", ew(5'b10000, 1'b0));
    cyc(REC - 20);
    chk("R11 still recov", mode, 6);
    cyc(30);
    chk("R11 standby", mode, 1); chk("R13 dv stays low", data_valid, 0);
    sleep_par("R9 one-shot", 5'b10000);
    cs_n = 0; ub_n = 0; we_n = 0; cyc(4); we_n = 1; cs_n = 1; ub_n = 1; cyc(4);
    chk("R13 dv restored", data_valid, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule